// File: doc/BRIEF.md
# ATA Taskfile Register File

This block is the device-side register file of an ATA port. A host reaches it over a byte-wide register bus. The bus has two chip selects: one for the command block and one for the control block. It also has a register address and separate read and write strobes. The block holds the feature, sector-count, three address bytes, device and command registers. Each of the five address-class registers keeps a second, older byte, so a host can load a 48-bit address by writing every register twice: the high-order byte first, then the low-order byte.

A command write raises BUSY and emits a one-cycle command pulse to a stubbed back end. When that back end reports completion, BUSY drops, DRQ takes the reported value, the error byte is loaded and an interrupt becomes pending. The interrupt output can be masked from the control register. Reading the status register acknowledges the pending interrupt. Reading the alternate status through the control block leaves it pending.

Top module: `tf_regfile`

## Requirements
- R1: After reset every stored byte is zero, status reads 0x40, the high-order select and the interrupt mask are clear, and `irq` is low.
- R2: An accepted write to offsets 1 to 5 moves that register's current byte into its high-order copy and stores the new byte as current.
- R3: While the high-order select (control bit 7) is set, reads of offsets 2 to 5 return the high-order copies and offset 1 returns the high-order feature byte. While it is clear, those reads return the current bytes.
- R4: Offset 1 is write-feature and read-error. The error byte reads back in place of the feature. It is loaded from `done_err` on completion and cleared when a command is issued.
- R5: A command write (offset 7) while not BUSY sets BUSY and clears DRQ and the error byte. In the next cycle `cmd_valid` is high for one cycle with `cmd_code` equal to the written byte. The status layout is: bit 7 BUSY, bit 6 ready (not BUSY), bit 3 DRQ, bit 0 error byte non-zero, and all other bits zero.
- R6: `done_valid` while BUSY clears BUSY, loads DRQ from `done_drq` and sets the pending interrupt. While not BUSY, `done_valid` has no effect.
- R7: `irq` is high exactly when an interrupt is pending and the mask bit (control bit 1) is clear.
- R8: A status read (offset 7) clears the pending interrupt. If a completion lands in the same cycle, the completion wins.
- R9: A control-block read returns the same byte as status and leaves the pending interrupt unchanged.
- R10: While BUSY, writes to offsets 1 to 5 and to offset 7 are ignored.
- R11: Any command-block write clears the high-order select, including a write that R10 ignores.
- R12: The device register (offset 6) is writable even while BUSY and reads back as written. Offset 0 reads zero and writes to it store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_sel | input | 1 | Command-block chip select |
| ctl_sel | input | 1 | Control-block chip select |
| reg_addr | input | 3 | Register offset within the command block |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; side effects apply at the clock edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational while `rd_en` is high, zero otherwise |
| done_valid | input | 1 | Completion report from the back end |
| done_drq | input | 1 | DRQ value reported with completion |
| done_err | input | 8 | Error byte reported with completion |
| cmd_valid | output | 1 | One-cycle pulse for an issued command |
| cmd_code | output | 8 | Command byte that goes with `cmd_valid` |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, command issue and completion take effect at the clock edge that samples them. Their results appear on `rd_data`, `irq` and `cmd_valid` during the following cycle. Read data is combinational and is due in the same cycle as `rd_en`, while the clear caused by a status read is seen one cycle after the read. The bench drives inputs on the falling edge and samples 2 ns later, still before the next rising edge. Each cycle it compares every output against a behavioural model that advances on the rising edge, so every result is checked in exactly the cycle it is due.

// File: rtl/tf_pkg.sv
package tf_pkg;
    // command-block offsets (host software depends on these)
    localparam int unsigned OFS_DATA    = 0;
    localparam int unsigned OFS_ERRFEAT = 1;
    localparam int unsigned OFS_DEV     = 6;
    localparam int unsigned OFS_STATCMD = 7;
    // offsets 1..5 carry a two-deep history
    localparam int unsigned FIRST_HIST  = 1;
    localparam int unsigned NUM_HIST    = 5;
    // status bit positions
    localparam int unsigned ST_BUSY  = 7;
    localparam int unsigned ST_READY = 6;
    localparam int unsigned ST_DRQ   = 3;
    localparam int unsigned ST_ERR   = 0;
    // control bit positions
    localparam int unsigned CT_MASK  = 1;
    localparam int unsigned CT_HOB   = 7;
endpackage

// File: rtl/tf_hist_byte.sv
module tf_hist_byte #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cur_q,
    output logic [DATA_W-1:0] old_q
);
    logic [DATA_W-1:0] cur_d, old_d;

    always_comb begin
        cur_d = cur_q;
        old_d = old_q;
        if (we) begin
            old_d = cur_q;
            cur_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
            old_q <= '0;
        end else begin
            cur_q <= cur_d;
            old_q <= old_d;
        end
    end

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (old_q == $past(cur_q)) && (cur_q == $past(wdata))); // R2
endmodule

// File: rtl/tf_ctl_state.sv
module tf_ctl_state
    import tf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_any,
    input  logic              cmd_issue,
    input  logic              ctl_wr,
    input  logic              stat_rd,
    input  logic              alt_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done_valid,
    input  logic              done_drq,
    input  logic [DATA_W-1:0] done_err,
    output logic              busy,
    output logic              hob,
    output logic [DATA_W-1:0] err_byte,
    output logic [DATA_W-1:0] status,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_code,
    output logic              irq
);
    typedef struct packed {
        logic              busy;
        logic              drq;
        logic              pend;
        logic              mask;
        logic              hob;
        logic              cmdv;
        logic [DATA_W-1:0] err;
        logic [DATA_W-1:0] cmdb;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cmdv = 1'b0;
        if (cmd_wr_any) st_d.hob = 1'b0;
        if (ctl_wr) begin
            st_d.mask = wdata[CT_MASK];
            st_d.hob  = wdata[CT_HOB];
        end
        if (cmd_issue && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.drq  = 1'b0;
            st_d.err  = '0;
            st_d.cmdv = 1'b1;
            st_d.cmdb = wdata;
        end
        if (stat_rd) st_d.pend = 1'b0;
        if (done_valid && st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.drq  = done_drq;
            st_d.err  = done_err;
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status           = '0;
        status[ST_BUSY]  = st_q.busy;
        status[ST_READY] = ~st_q.busy;
        status[ST_DRQ]   = st_q.drq;
        status[ST_ERR]   = |st_q.err;
    end

    assign busy      = st_q.busy;
    assign hob       = st_q.hob;
    assign err_byte  = st_q.err;
    assign cmd_valid = st_q.cmdv;
    assign cmd_code  = st_q.cmdb;
    assign irq       = st_q.pend & ~st_q.mask;

    AST_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && !busy) |=> (busy && cmd_valid && cmd_code == $past(wdata))); // R5
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && busy) |=> (!busy && st_q.pend)); // R6
    AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !busy && !cmd_issue && !stat_rd) |=> (!busy && $stable(st_q.pend))); // R6
    AST_MASK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && wdata[CT_MASK]) |=> !irq); // R7
    AST_STAT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(done_valid && busy)) |=> !irq); // R8
    AST_ALT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_rd && !stat_rd && st_q.pend) |=> st_q.pend); // R9
    AST_HOB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_any && !ctl_wr) |=> !hob); // R11
endmodule

// File: rtl/tf_read_mux.sv
module tf_read_mux
    import tf_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                             rd_en,
    input  logic                             cmd_sel,
    input  logic                             ctl_sel,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic                             hob,
    input  logic [NUM_HIST-1:0][DATA_W-1:0]  hist_cur,
    input  logic [NUM_HIST-1:0][DATA_W-1:0]  hist_old,
    input  logic [DATA_W-1:0]                err_byte,
    input  logic [DATA_W-1:0]                dev_byte,
    input  logic [DATA_W-1:0]                status,
    output logic [DATA_W-1:0]                rd_data
);
    logic [DATA_W-1:0] cmd_blk;

    always_comb begin
        cmd_blk = '0;
        for (int g = 0; g < NUM_HIST; g++) begin
            if (reg_addr == ADDR_W'(FIRST_HIST + g))
                cmd_blk = hob ? hist_old[g] : hist_cur[g];
        end
        if (reg_addr == ADDR_W'(OFS_ERRFEAT) && !hob) cmd_blk = err_byte;
        if (reg_addr == ADDR_W'(OFS_DEV))             cmd_blk = dev_byte;
        if (reg_addr == ADDR_W'(OFS_STATCMD))         cmd_blk = status;
        if (reg_addr == ADDR_W'(OFS_DATA))            cmd_blk = '0;
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (ctl_sel)      rd_data = status;
            else if (cmd_sel) rd_data = cmd_blk;
        end
    end
endmodule

// File: rtl/tf_regfile.sv
module tf_regfile
    import tf_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_sel,
    input  logic              ctl_sel,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              done_valid,
    input  logic              done_drq,
    input  logic [DATA_W-1:0] done_err,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_code,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_DEV  = ADDR_W'(OFS_DEV);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATCMD);

    logic                            cmd_wr, ctl_wr, stat_rd, alt_rd, cmd_issue;
    logic                            busy, hob;
    logic [DATA_W-1:0]               err_byte, status;
    logic [DATA_W-1:0]               dev_d, dev_q;
    logic [NUM_HIST-1:0]             hist_we;
    logic [NUM_HIST-1:0][DATA_W-1:0] hist_cur, hist_old;
    logic                            hist_hit;

    assign cmd_wr    = cmd_sel & wr_en;
    assign ctl_wr    = ctl_sel & wr_en;
    assign stat_rd   = cmd_sel & rd_en & (reg_addr == A_STAT);
    assign alt_rd    = ctl_sel & rd_en;
    assign cmd_issue = cmd_wr & (reg_addr == A_STAT);

    generate
        for (genvar g = 0; g < NUM_HIST; g++) begin : g_hist
            assign hist_we[g] = cmd_wr & ~busy & (reg_addr == ADDR_W'(FIRST_HIST + g));
            tf_hist_byte #(.DATA_W(DATA_W)) u_hist (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (hist_we[g]),
                .wdata (wr_data),
                .cur_q (hist_cur[g]),
                .old_q (hist_old[g])
            );
        end
    endgenerate

    always_comb begin
        hist_hit = 1'b0;
        for (int g = 0; g < NUM_HIST; g++)
            if (reg_addr == ADDR_W'(FIRST_HIST + g)) hist_hit = 1'b1;
    end

    always_comb begin
        dev_d = dev_q;
        if (cmd_wr && reg_addr == A_DEV) dev_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dev_q <= '0;
        else        dev_q <= dev_d;
    end

    tf_ctl_state #(.DATA_W(DATA_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr_any (cmd_wr),
        .cmd_issue  (cmd_issue),
        .ctl_wr     (ctl_wr),
        .stat_rd    (stat_rd),
        .alt_rd     (alt_rd),
        .wdata      (wr_data),
        .done_valid (done_valid),
        .done_drq   (done_drq),
        .done_err   (done_err),
        .busy       (busy),
        .hob        (hob),
        .err_byte   (err_byte),
        .status     (status),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .irq        (irq)
    );

    tf_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rd_en    (rd_en),
        .cmd_sel  (cmd_sel),
        .ctl_sel  (ctl_sel),
        .reg_addr (reg_addr),
        .hob      (hob),
        .hist_cur (hist_cur),
        .hist_old (hist_old),
        .err_byte (err_byte),
        .dev_byte (dev_q),
        .status   (status),
        .rd_data  (rd_data)
    );

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && hist_hit && busy) |=> ($stable(hist_cur) && $stable(hist_old))); // R10
    AST_DEV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_addr == A_DEV) |=> (dev_q == $past(wr_data))); // R12
    AST_ALT_EQ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_rd && !cmd_sel) |-> (rd_data == status)); // R9
endmodule

// File: tb/tb_tf_regfile.sv
`timescale 1ns/100ps
module tb_tf_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_sel = 0, ctl_sel = 0, wr_en = 0, rd_en = 0;
    logic [2:0] reg_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       done_valid = 0, done_drq = 0;
    logic [7:0] done_err = '0;
    logic       cmd_valid, irq;
    logic [7:0] cmd_code;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tf_regfile dut (
        .clk(clk), .rst_n(rst_n), .cmd_sel(cmd_sel), .ctl_sel(ctl_sel),
        .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
        .rd_data(rd_data), .done_valid(done_valid), .done_drq(done_drq),
        .done_err(done_err), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .irq(irq)
    );

    // behavioural reference model
    logic [7:0] m_cur [1:5];
    logic [7:0] m_old [1:5];
    logic [7:0] m_dev, m_err, m_cmdb;
    logic       m_busy, m_drq, m_pend, m_mask, m_hob, m_cmdv;

    function automatic logic [7:0] m_status();
        return {m_busy, ~m_busy, 2'b00, m_drq, 2'b00, |m_err};
    endfunction

    function automatic logic [7:0] m_read(input logic c, input logic k, input logic [2:0] a);
        if (k) return m_status();
        if (!c) return 8'h00;
        case (a)
            3'd1:                   return m_hob ? m_old[1] : m_err;
            3'd2, 3'd3, 3'd4, 3'd5: return m_hob ? m_old[a] : m_cur[a];
            3'd6:                   return m_dev;
            3'd7:                   return m_status();
            default:                return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 1; i <= 5; i++) begin m_cur[i] = 0; m_old[i] = 0; end
            m_dev = 0; m_err = 0; m_cmdb = 0;
            m_busy = 0; m_drq = 0; m_pend = 0; m_mask = 0; m_hob = 0; m_cmdv = 0;
        end else begin
            logic b0;
            b0 = m_busy;
            m_cmdv = 0;
            if (cmd_sel && wr_en) begin
                m_hob = 0;
                if (reg_addr >= 1 && reg_addr <= 5 && !b0) begin
                    m_old[reg_addr] = m_cur[reg_addr];
                    m_cur[reg_addr] = wr_data;
                end
                if (reg_addr == 6) m_dev = wr_data;
                if (reg_addr == 7 && !b0) begin
                    m_busy = 1; m_drq = 0; m_err = 0; m_cmdv = 1; m_cmdb = wr_data;
                end
            end
            if (ctl_sel && wr_en) begin
                m_mask = wr_data[1];
                m_hob  = wr_data[7];
            end
            if (cmd_sel && rd_en && reg_addr == 7) m_pend = 0;
            if (done_valid && b0) begin
                m_busy = 0; m_drq = done_drq; m_err = done_err; m_pend = 1;
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rd_tag(input logic k, input logic [2:0] a);
        if (k) return "R9 alt status";
        case (a)
            3'd0, 3'd6: return "R12 data/device read";
            3'd1:       return "R4 error read";
            3'd7:       return "R5 status read";
            default:    return "R3 history read";
        endcase
    endfunction

    // per-cycle comparison against the model, 2 ns after the falling edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            chk({7'd0, irq}, {7'd0, m_pend & ~m_mask}, "R7 irq vs model");
            chk({7'd0, cmd_valid}, {7'd0, m_cmdv}, "R5 cmd_valid vs model");
            if (m_cmdv) chk(cmd_code, m_cmdb, "R5 cmd_code vs model");
            if (rd_en) chk(rd_data, m_read(cmd_sel, ctl_sel, reg_addr), rd_tag(ctl_sel, reg_addr));
        end
    end

    task automatic clear_in();
        cmd_sel = 0; ctl_sel = 0; wr_en = 0; rd_en = 0; done_valid = 0;
        done_drq = 0; done_err = 0; reg_addr = 0; wr_data = 0;
    endtask

    task automatic wr(input logic k, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_sel = ~k; ctl_sel = k; wr_en = 1; reg_addr = a; wr_data = d;
        @(negedge clk);
        clear_in();
    endtask

    task automatic rd(input logic k, input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cmd_sel = ~k; ctl_sel = k; rd_en = 1; reg_addr = a;
        #1 chk(rd_data, exp, tag);
        @(negedge clk);
        clear_in();
    endtask

    task automatic finish_cmd(input logic drq, input logic [7:0] e);
        @(negedge clk);
        done_valid = 1; done_drq = drq; done_err = e;
        @(negedge clk);
        clear_in();
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        #1 chk({7'd0, irq}, {7'd0, exp}, tag);
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
    end

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1 reset state
        chk_irq(0, "R1 irq after reset");
        rd(0, 3'd7, 8'h40, "R1 status after reset");
        rd(1, 3'd0, 8'h40, "R1 alt status after reset");
        rd(0, 3'd3, 8'h00, "R1 lba byte after reset");
        // R2 / R3 two-deep history
        wr(0, 3'd3, 8'h11);
        wr(0, 3'd3, 8'h22);
        rd(0, 3'd3, 8'h22, "R2 current byte");
        wr(1, 3'd0, 8'h80);
        rd(0, 3'd3, 8'h11, "R3 high-order copy");
        rd(0, 3'd4, 8'h00, "R3 high-order copy unwritten");
        // R11 any command-block write clears select
        wr(0, 3'd2, 8'h05);
        rd(0, 3'd3, 8'h22, "R11 select dropped");
        rd(0, 3'd2, 8'h05, "R2 count current");
        // R4 error shares offset 1
        wr(0, 3'd1, 8'h33);
        rd(0, 3'd1, 8'h00, "R4 error not feature");
        wr(0, 3'd1, 8'h44);
        wr(1, 3'd0, 8'h80);
        rd(0, 3'd1, 8'h33, "R3 high-order feature");
        // R12 device and data port
        wr(0, 3'd6, 8'hE0);
        rd(0, 3'd6, 8'hE0, "R12 device readback");
        wr(0, 3'd0, 8'h99);
        rd(0, 3'd0, 8'h00, "R12 data port reads zero");
        // R5 command issue
        wr(0, 3'd7, 8'h25);
        rd(0, 3'd7, 8'h80, "R5 busy status");
        // R10 writes ignored while busy; R12 device still writable
        wr(0, 3'd3, 8'h77);
        rd(0, 3'd3, 8'h22, "R10 lba unchanged while busy");
        wr(0, 3'd7, 8'h30);
        wr(0, 3'd6, 8'hF0);
        rd(0, 3'd6, 8'hF0, "R12 device written while busy");
        // R6 completion
        finish_cmd(1, 8'h04);
        rd(0, 3'd1, 8'h04, "R4 error loaded");
        chk_irq(1, "R6 completion raises irq");
        // R9 alternate status keeps interrupt
        rd(1, 3'd0, 8'h49, "R9 alt status value");
        chk_irq(1, "R9 irq kept after alt read");
        // R7 masking
        wr(1, 3'd0, 8'h02);
        chk_irq(0, "R7 masked");
        wr(1, 3'd0, 8'h00);
        chk_irq(1, "R7 unmasked");
        // R8 status read acknowledges
        rd(0, 3'd7, 8'h49, "R8 status value");
        chk_irq(0, "R8 cleared by status read");
        // R6 completion while idle ignored
        finish_cmd(0, 8'h00);
        rd(0, 3'd7, 8'h49, "R6 idle completion ignored");
        chk_irq(0, "R6 no irq from idle completion");
        // R5 issue clears drq and error
        wr(0, 3'd7, 8'hC8);
        rd(0, 3'd7, 8'h80, "R5 issue clears drq/error");
        // R8 completion beats same-cycle status read
        @(negedge clk);
        cmd_sel = 1; rd_en = 1; reg_addr = 3'd7; done_valid = 1;
        @(negedge clk);
        clear_in();
        chk_irq(1, "R8 completion wins");
        rd(0, 3'd7, 8'h40, "R6 idle after completion");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule